// File: doc/BRIEF.md
# Clock Mode Transition Controller

This block tracks which system clock mode a device is running in and decides whether each mode change that software asks for may be applied. Software presents a full control word (sub oscillator enable, main oscillator off, divide controls, sub clock select, the two PLL select bits and the on-chip oscillator select) together with a write strobe. The controller works out the mode that word would produce and compares it with the current mode against a fixed table of permitted moves. A permitted word is stored. A refused word changes nothing and raises a one-cycle error flag.

Low-power entry is modelled as well. A stop request or a wait command parks the block in stop or wait mode. A hardware wake interrupt brings it back to the mode it held before entry. The controller also applies the forced divide-by-8 setting when the main oscillator is switched off and when stop mode is left. Oscillators are level inputs here; analog behaviour, PLL lock and glitch-free clock switching are outside this block.

Top module: `clkm_ctrl`

## Requirements
- R1: After reset, mode is 0 (high/medium speed), source is 0 (main), the main oscillator is on, the sub oscillator enable is off, the div8 bit is 1, the ratio is 8 and the error flag is 0.
- R2: The ratio output is 8 whenever div8 is 1. Otherwise the 2-bit divide field gives the ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R3: A refused request leaves mode, source, ratio and control bits unchanged and sets the error flag for exactly the one cycle after the request.
- R4: PLL mode (code 3) can be entered only from mode 0 and can be left only to mode 0. A stop request or a wait command made in PLL mode is refused.
- R5: A move from mode 0 to low-speed mode (code 1, sub clock selected with the main oscillator on) is accepted only while the sub oscillator running input is 1. Selecting the sub clock with its enable bit at 0 is always refused.
- R6: An accepted write with the main-off bit at 1 stores div8 as 1, whatever div8 value was written. A main-off write that selects neither the sub clock nor the on-chip oscillator is refused.
- R7: Leaving stop mode sets div8 to 1. Leaving wait mode keeps the divide setting.
- R8: A move from on-chip oscillator mode (code 4) to mode 0 is accepted only if the stored div8 bit is already 1 when the request is made.
- R9: A stop request enters mode 6 and a wait command enters mode 7. Only the wake interrupt leaves either mode, and it returns to the mode held before entry. Writes made in mode 6 or 7 are refused.
- R10: While the detection-enable input is 1, every request that would change the mode (including stop and wait entry) is refused. Writes that keep the same mode are still accepted.
- R11: Mode 3 with source 2 needs both PLL select bits at 1. With only one of them set, the main clock (source 0) stays selected. Clearing both returns the block to mode 0, source 0.
- R12: Permitted moves are 0 to {1, 3, 4}; 1 to {0, 2}; 2 to {1}; 3 to {0}; 4 to {0, 5}; 5 to {4}. Mode 2 is the sub clock with the main oscillator off, and mode 5 is the on-chip oscillator with the main oscillator off. Writes that keep the current mode are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_sub_on | input | 1 | Sub oscillator enable |
| wr_main_off | input | 1 | Main oscillator off |
| wr_div8 | input | 1 | Force divide-by-8 |
| wr_div_sel | input | 2 | Divide field |
| wr_sel_sub | input | 1 | Select sub clock as CPU source |
| wr_pll_a | input | 1 | PLL select bit, first of two |
| wr_pll_b | input | 1 | PLL select bit, second of two |
| wr_ring_sel | input | 1 | Select on-chip oscillator |
| det_en | input | 1 | Oscillation-stop detection enable |
| sub_running | input | 1 | Sub oscillator is running |
| stop_req | input | 1 | Stop mode request |
| wait_cmd | input | 1 | Wait mode command |
| wake_irq | input | 1 | Hardware wake interrupt |
| mode | output | 3 | Current mode code |
| src | output | 2 | Source: 0 main, 1 sub, 2 PLL, 3 on-chip |
| div_ratio | output | DIV_W | CPU divide ratio |
| div8_o | output | 1 | Stored div8 bit |
| sub_on_o | output | 1 | Stored sub oscillator enable |
| main_off_o | output | 1 | Stored main-off bit |
| illegal | output | 1 | One-cycle refused-request flag |

## Verification
The bench builds the block with the default ratio width of 5 bits. That width is the smallest that can hold the largest ratio, 16, so the full set of ratios (1, 2, 4, 8, 16) can be observed at the port. The directed scenarios walk the mode graph from mode 0 through PLL, the sub clock modes and the on-chip oscillator modes, and through stop and wait. At each step the bench mixes accepted moves with moves that must be refused, so that both an unchanged state and the one-cycle error flag are observed.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

    typedef enum logic [2:0] {
        M_FAST   = 3'd0,
        M_SLOW   = 3'd1,
        M_LOWPWR = 3'd2,
        M_PLL    = 3'd3,
        M_RING   = 3'd4,
        M_RINGLP = 3'd5,
        M_STOP   = 3'd6,
        M_WAIT   = 3'd7
    } cmode_t;

    typedef enum logic [1:0] {
        S_MAIN = 2'd0,
        S_SUB  = 2'd1,
        S_PLL  = 2'd2,
        S_RING = 2'd3
    } csrc_t;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_STOP = 2'd1,
        LP_WAIT = 2'd2
    } lp_t;

    typedef struct packed {
        logic       sub_on;
        logic       main_off;
        logic       div8;
        logic [1:0] div_sel;
        logic       sel_sub;
        logic       pll_a;
        logic       pll_b;
        logic       ring_sel;
    } cctl_t;

    localparam cctl_t CTL_RESET = '{sub_on: 1'b0, main_off: 1'b0, div8: 1'b1,
                                    div_sel: 2'b00, sel_sub: 1'b0, pll_a: 1'b0,
                                    pll_b: 1'b0, ring_sel: 1'b0};

    // Running mode implied by a control word (priority: on-chip, sub, PLL).
    function automatic cmode_t run_mode(cctl_t c);
        if (c.ring_sel)             return c.main_off ? M_RINGLP : M_RING;
        else if (c.sel_sub)         return c.main_off ? M_LOWPWR : M_SLOW;
        else if (c.pll_a && c.pll_b) return M_PLL;
        else                        return M_FAST;
    endfunction

    function automatic csrc_t src_of(cctl_t c);
        if (c.ring_sel)             return S_RING;
        else if (c.sel_sub)         return S_SUB;
        else if (c.pll_a && c.pll_b) return S_PLL;
        else                        return S_MAIN;
    endfunction

    // A word is self-consistent when the selected source is actually on.
    function automatic logic cfg_ok(cctl_t c);
        return !(c.sel_sub && !c.ring_sel && !c.sub_on) &&
               !(c.main_off && !c.ring_sel && !c.sel_sub);
    endfunction

    // Table of permitted moves between distinct running modes.
    function automatic logic move_ok(cmode_t cur, cmode_t nxt,
                                     logic sub_run, logic div8_now);
        case (cur)
            M_FAST:   return (nxt == M_SLOW && sub_run) || nxt == M_PLL || nxt == M_RING;
            M_SLOW:   return nxt == M_FAST || nxt == M_LOWPWR;
            M_LOWPWR: return nxt == M_SLOW;
            M_PLL:    return nxt == M_FAST;
            M_RING:   return (nxt == M_FAST && div8_now) || nxt == M_RINGLP;
            M_RINGLP: return nxt == M_RING;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clkm_div.sv
module clkm_div #(
    parameter int DIV_W = 5
) (
    input  logic             div8,
    input  logic [1:0]       div_sel,
    output logic [DIV_W-1:0] ratio
);
    localparam logic [DIV_W-1:0] R8  = DIV_W'(8);
    localparam logic [DIV_W-1:0] R16 = DIV_W'(16);

    always_comb begin
        if (div8)                 ratio = R8;
        else if (div_sel == 2'b11) ratio = R16;
        else                      ratio = DIV_W'(1) << div_sel;
    end
endmodule

// File: rtl/clkm_arbiter.sv
module clkm_arbiter
    import clkm_pkg::*;
(
    input  cctl_t cur_ctl,
    input  lp_t   lp,
    input  logic  wr_en,
    input  cctl_t wr_ctl,
    input  logic  det_en,
    input  logic  sub_running,
    input  logic  stop_req,
    input  logic  wait_cmd,
    input  logic  wake_irq,
    output logic  take_wr,
    output logic  lp_load,
    output lp_t   lp_next,
    output logic  stop_wake,
    output logic  reject
);
    cmode_t cur_m;
    cmode_t nxt_m;

    always_comb begin
        cur_m     = run_mode(cur_ctl);
        nxt_m     = run_mode(wr_ctl);
        take_wr   = 1'b0;
        lp_load   = 1'b0;
        lp_next   = lp;
        stop_wake = 1'b0;
        reject    = 1'b0;
        if (lp != LP_RUN) begin
            if (wake_irq) begin
                lp_load   = 1'b1;
                lp_next   = LP_RUN;
                stop_wake = (lp == LP_STOP);
            end
            reject = wr_en | stop_req | wait_cmd;
        end else if (stop_req || wait_cmd) begin
            if (!det_en && cur_m != M_PLL) begin
                lp_load = 1'b1;
                lp_next = stop_req ? LP_STOP : LP_WAIT;
            end else begin
                reject = 1'b1;
            end
        end else if (wr_en) begin
            if (cfg_ok(wr_ctl) &&
                (nxt_m == cur_m ||
                 (!det_en && move_ok(cur_m, nxt_m, sub_running, cur_ctl.div8))))
                take_wr = 1'b1;
            else
                reject = 1'b1;
        end
    end
endmodule

// File: rtl/clkm_ctl_reg.sv
module clkm_ctl_reg
    import clkm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_wr,
    input  cctl_t wr_ctl,
    input  logic  stop_wake,
    output cctl_t ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (take_wr) begin
            ctl <= wr_ctl;
            if (wr_ctl.main_off) ctl.div8 <= 1'b1;
        end else if (stop_wake) begin
            ctl.div8 <= 1'b1;
        end
    end
endmodule

// File: rtl/clkm_ctrl.sv
module clkm_ctrl
    import clkm_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sub_on,
    input  logic             wr_main_off,
    input  logic             wr_div8,
    input  logic [1:0]       wr_div_sel,
    input  logic             wr_sel_sub,
    input  logic             wr_pll_a,
    input  logic             wr_pll_b,
    input  logic             wr_ring_sel,
    input  logic             det_en,
    input  logic             sub_running,
    input  logic             stop_req,
    input  logic             wait_cmd,
    input  logic             wake_irq,
    output logic [2:0]       mode,
    output logic [1:0]       src,
    output logic [DIV_W-1:0] div_ratio,
    output logic             div8_o,
    output logic             sub_on_o,
    output logic             main_off_o,
    output logic             illegal
);
    cctl_t ctl;
    cctl_t wr_ctl;
    lp_t   lp;
    lp_t   lp_next;
    logic  take_wr;
    logic  lp_load;
    logic  stop_wake;
    logic  reject;

    always_comb begin
        wr_ctl.sub_on   = wr_sub_on;
        wr_ctl.main_off = wr_main_off;
        wr_ctl.div8     = wr_div8;
        wr_ctl.div_sel  = wr_div_sel;
        wr_ctl.sel_sub  = wr_sel_sub;
        wr_ctl.pll_a    = wr_pll_a;
        wr_ctl.pll_b    = wr_pll_b;
        wr_ctl.ring_sel = wr_ring_sel;
    end

    clkm_arbiter i_arb (
        .cur_ctl(ctl), .lp(lp), .wr_en(wr_en), .wr_ctl(wr_ctl),
        .det_en(det_en), .sub_running(sub_running), .stop_req(stop_req),
        .wait_cmd(wait_cmd), .wake_irq(wake_irq), .take_wr(take_wr),
        .lp_load(lp_load), .lp_next(lp_next), .stop_wake(stop_wake),
        .reject(reject)
    );

    clkm_ctl_reg i_ctl (
        .clk(clk), .rst(rst), .take_wr(take_wr), .wr_ctl(wr_ctl),
        .stop_wake(stop_wake), .ctl(ctl)
    );

    clkm_div #(.DIV_W(DIV_W)) i_div (
        .div8(ctl.div8), .div_sel(ctl.div_sel), .ratio(div_ratio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lp      <= LP_RUN;
            illegal <= 1'b0;
        end else begin
            if (lp_load) lp <= lp_next;
            illegal <= reject;
        end
    end

    always_comb begin
        case (lp)
            LP_STOP: mode = M_STOP;
            LP_WAIT: mode = M_WAIT;
            default: mode = run_mode(ctl);
        endcase
        src        = src_of(ctl);
        div8_o     = ctl.div8;
        sub_on_o   = ctl.sub_on;
        main_off_o = ctl.main_off;
    end
endmodule

// File: rtl/clkm_ctrl_chk.sv
module clkm_ctrl_chk #(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             det_en,
    input logic             sub_running,
    input logic             wake_irq,
    input logic [2:0]       mode,
    input logic [1:0]       src,
    input logic [DIV_W-1:0] div_ratio,
    input logic             div8_o,
    input logic             main_off_o,
    input logic             illegal
);
    p_div8_ratio_r2: assert property (@(posedge clk) disable iff (rst)
        div8_o |-> div_ratio == DIV_W'(8));

    p_reject_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (illegal && !$past(rst)) |->
            (mode == $past(mode) && src == $past(src) && div_ratio == $past(div_ratio)));

    p_pll_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode == 3'd3 && $past(mode) != 3'd3) |-> $past(mode) == 3'd0);

    p_pll_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'd3 && mode != 3'd3) |-> mode == 3'd0);

    p_slow_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode == 3'd1 && $past(mode) == 3'd0) |-> $past(sub_running));

    p_mainoff_div8_r6: assert property (@(posedge clk) disable iff (rst)
        main_off_o |-> div8_o);

    p_stop_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'd6 && mode != 3'd6) |-> div8_o);

    p_ring_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'd4 && mode == 3'd0) |-> $past(div8_o));

    p_wake_only_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode) == 3'd6 || $past(mode) == 3'd7) && mode != $past(mode))
            |-> $past(wake_irq));

    p_detect_block_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(det_en) && !$past(wake_irq)) |-> mode == $past(mode));
endmodule

bind clkm_ctrl clkm_ctrl_chk #(.DIV_W(DIV_W)) i_chk (
    .clk(clk), .rst(rst), .det_en(det_en), .sub_running(sub_running),
    .wake_irq(wake_irq), .mode(mode), .src(src), .div_ratio(div_ratio),
    .div8_o(div8_o), .main_off_o(main_off_o), .illegal(illegal)
);

// File: tb/test_clkm_ctrl.sv
module test_clkm_ctrl;
    localparam int DIV_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_sub_on = 0, wr_main_off = 0, wr_div8 = 0;
    logic [1:0] wr_div_sel = 0;
    logic wr_sel_sub = 0, wr_pll_a = 0, wr_pll_b = 0, wr_ring_sel = 0;
    logic det_en = 0, sub_running = 0, stop_req = 0, wait_cmd = 0, wake_irq = 0;
    logic [2:0] mode;
    logic [1:0] src;
    logic [DIV_W-1:0] div_ratio;
    logic div8_o, sub_on_o, main_off_o, illegal;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    clkm_ctrl #(.DIV_W(DIV_W)) i_clkm_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sub_on(wr_sub_on),
        .wr_main_off(wr_main_off), .wr_div8(wr_div8), .wr_div_sel(wr_div_sel),
        .wr_sel_sub(wr_sel_sub), .wr_pll_a(wr_pll_a), .wr_pll_b(wr_pll_b),
        .wr_ring_sel(wr_ring_sel), .det_en(det_en), .sub_running(sub_running),
        .stop_req(stop_req), .wait_cmd(wait_cmd), .wake_irq(wake_irq),
        .mode(mode), .src(src), .div_ratio(div_ratio), .div8_o(div8_o),
        .sub_on_o(sub_on_o), .main_off_o(main_off_o), .illegal(illegal)
    );

    task automatic check(input string req, input logic [2:0] m, input logic [1:0] s,
                         input int r, input logic ill);
        n_tests++;
        if (mode !== m || src !== s || div_ratio !== DIV_W'(r) || illegal !== ill) begin
            n_fail++;
            $display("FAIL %s: mode=%0d src=%0d ratio=%0d illegal=%0d expected mode=%0d src=%0d ratio=%0d illegal=%0d",
                     req, mode, src, div_ratio, illegal, m, s, r, ill);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one control word for one cycle; returns at the next falling edge.
    task automatic wr(input logic so, mo, d8, input logic [1:0] ds,
                      input logic ss, pa, pb, rs);
        wr_en = 1; wr_sub_on = so; wr_main_off = mo; wr_div8 = d8; wr_div_sel = ds;
        wr_sel_sub = ss; wr_pll_a = pa; wr_pll_b = pb; wr_ring_sel = rs;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_stop();
        stop_req = 1; @(negedge clk); stop_req = 0;
    endtask

    task automatic pulse_wait();
        wait_cmd = 1; @(negedge clk); wait_cmd = 0;
    endtask

    task automatic pulse_irq();
        wake_irq = 1; @(negedge clk); wake_irq = 0;
    endtask

    task automatic t_reset();
        check("R1 reset", 3'd0, 2'd0, 8, 1'b0);
        check_bit("R1 div8", div8_o, 1'b1);
        check_bit("R1 sub_on", sub_on_o, 1'b0);
        check_bit("R1 main_off", main_off_o, 1'b0);
    endtask

    task automatic t_divide();
        wr(0,0,0,2'b00,0,0,0,0); check("R2 div1 R12", 3'd0, 2'd0, 1, 1'b0);
        wr(0,0,0,2'b01,0,0,0,0); check("R2 div2", 3'd0, 2'd0, 2, 1'b0);
        wr(0,0,0,2'b10,0,0,0,0); check("R2 div4", 3'd0, 2'd0, 4, 1'b0);
        wr(0,0,0,2'b11,0,0,0,0); check("R2 div16", 3'd0, 2'd0, 16, 1'b0);
        wr(0,0,1,2'b01,0,0,0,0); check("R2 div8 overrides", 3'd0, 2'd0, 8, 1'b0);
    endtask

    task automatic t_pll();
        wr(0,0,1,2'b00,0,1,0,0); check("R11 one pll bit", 3'd0, 2'd0, 8, 1'b0);
        wr(0,0,1,2'b00,0,1,1,0); check("R11 pll entry", 3'd3, 2'd2, 8, 1'b0);
        sub_running = 1;
        wr(1,0,1,2'b00,1,0,0,0); check("R4 pll to slow refused", 3'd3, 2'd2, 8, 1'b1);
        @(negedge clk);          check("R3 flag one cycle", 3'd3, 2'd2, 8, 1'b0);
        pulse_stop();            check("R4 stop in pll refused", 3'd3, 2'd2, 8, 1'b1);
        wr(0,0,1,2'b00,0,0,0,0); check("R11 pll exit", 3'd0, 2'd0, 8, 1'b0);
        sub_running = 0;
    endtask

    task automatic t_sub();
        wr(1,0,1,2'b00,1,0,0,0); check("R5 sub not running", 3'd0, 2'd0, 8, 1'b1);
        sub_running = 1;
        wr(0,0,1,2'b00,1,0,0,0); check("R5 sub enable off", 3'd0, 2'd0, 8, 1'b1);
        wr(1,0,1,2'b00,1,0,0,0); check("R5 slow entry", 3'd1, 2'd1, 8, 1'b0);
        wr(1,0,1,2'b00,0,1,1,0); check("R12 slow to pll refused", 3'd1, 2'd1, 8, 1'b1);
        wr(1,1,0,2'b00,1,0,0,0); check("R6 lowpwr forces div8", 3'd2, 2'd1, 8, 1'b0);
        check_bit("R6 div8 bit", div8_o, 1'b1);
        wr(1,0,1,2'b00,0,0,0,0); check("R12 lowpwr to fast refused", 3'd2, 2'd1, 8, 1'b1);
        wr(1,0,0,2'b01,1,0,0,0); check("R12 lowpwr to slow", 3'd1, 2'd1, 2, 1'b0);
        wr(1,0,0,2'b01,0,0,0,0); check("R12 slow to fast", 3'd0, 2'd0, 2, 1'b0);
        wr(0,1,0,2'b00,0,0,0,0); check("R6 main off without source", 3'd0, 2'd0, 2, 1'b1);
        sub_running = 0;
    endtask

    task automatic t_ring();
        wr(0,0,0,2'b00,0,0,0,1); check("R12 ring entry", 3'd4, 2'd3, 1, 1'b0);
        wr(0,0,1,2'b00,0,0,0,0); check("R8 ring exit div8 clear", 3'd4, 2'd3, 1, 1'b1);
        wr(0,1,0,2'b00,0,0,0,1); check("R12 ringlp R6", 3'd5, 2'd3, 8, 1'b0);
        wr(0,0,1,2'b00,0,0,0,0); check("R12 ringlp to fast refused", 3'd5, 2'd3, 8, 1'b1);
        wr(0,0,1,2'b00,0,0,0,1); check("R12 ringlp to ring", 3'd4, 2'd3, 8, 1'b0);
        wr(0,0,0,2'b00,0,0,0,0); check("R8 ring exit div8 set", 3'd0, 2'd0, 1, 1'b0);
    endtask

    task automatic t_stop_wait();
        pulse_stop();            check("R9 stop entry", 3'd6, 2'd0, 1, 1'b0);
        wr(0,0,0,2'b01,0,0,0,0); check("R9 write in stop refused", 3'd6, 2'd0, 1, 1'b1);
        pulse_irq();             check("R7 stop exit div8", 3'd0, 2'd0, 8, 1'b0);
        wr(0,0,0,2'b01,0,0,0,0); check("R2 setup", 3'd0, 2'd0, 2, 1'b0);
        pulse_wait();            check("R9 wait entry", 3'd7, 2'd0, 2, 1'b0);
        @(negedge clk);          check("R9 wait holds", 3'd7, 2'd0, 2, 1'b0);
        pulse_irq();             check("R7 wait exit keeps div", 3'd0, 2'd0, 2, 1'b0);
    endtask

    task automatic t_detect();
        det_en = 1;
        wr(0,0,1,2'b00,0,1,1,0); check("R10 pll blocked", 3'd0, 2'd0, 2, 1'b1);
        wr(0,0,0,2'b10,0,0,0,0); check("R10 same mode allowed", 3'd0, 2'd0, 4, 1'b0);
        pulse_stop();            check("R10 stop blocked", 3'd0, 2'd0, 4, 1'b1);
        det_en = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_divide();
        t_pll();
        t_sub();
        t_ring();
        t_stop_wait();
        t_detect();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule